// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 32-bit system-bus address into one of eight one-hot chip-select lines. Each bank owns one configuration word holding a 128 KiB-aligned base, a per-bit match mask and an enable flag. Software reaches these words through a small register port. The chip selects, the hit flag and the miss flag follow the bus address combinationally. A registered copy of the hit flag is also provided for logic that needs a clean, clocked version.

A strap input is latched while reset is held. When the strap is set, the outputs of configuration words 0 and 1 trade places, so word 0 drives chip select 1 and word 1 drives chip select 0. The block also reproduces a known hardware quirk. If word 0 or word 1 holds zero, that word takes every bus access and no higher bank can be reached. An unused low bank is therefore parked by writing all ones to it.

Top module: `cs_addr_decoder`

## Requirements
- R1: Reset values. Word 0 resets to 0x0000FFFF with the strap clear and to 0x0000FFFE with it set. Word 1 resets to 0x0000FFFE with the strap clear and to 0x0000FFFF with it set. Words 2 to 7 reset to 0.
- R2: Word layout and addressing.
  - Word k sits at byte offset 16*k.
  - Bits [31:17] hold the base, bits [15:1] hold the mask and bit 0 is the enable.
  - Bit 16 always reads as 0.
- R3: Matching. An enabled word matches when, for every set mask bit j (register bit j+1), address bit 17+j equals base bit j. Cleared mask bits are don't-care.
- R4: A word whose enable bit is clear never asserts a chip select. The only exception is R6.
- R5: When several words match, only the lowest-numbered one asserts its select, so cs is always one-hot or zero.
- R6: If word 0 or word 1 is entirely zero, every address selects that word. Word 0 takes precedence over word 1.
- R7: All ones written to word 0 or 1 does not capture the bus. Such a word matches only addresses whose bits [31:17] are all ones, and lower addresses fall through to higher banks.
- R8: Swap strap.
  - The strap is sampled only while reset is high.
  - When the latched strap is set, word 0 drives cs[1] and word 1 drives cs[0]. All other words keep their own lines.
  - Changing the strap after reset has no effect.
- R9: A write to any offset that is not a word address changes nothing, and a read from such an offset returns 0.
- R10: Read data is registered and appears one cycle after the address. A write takes effect on the decode in the cycle after the write strobe.
- R11: hit is the OR of cs and miss is its inverse, both combinational. hit_valid equals hit delayed by one cycle and is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_strap | input | 1 | Boot-swap strap, latched during reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| bus_addr | input | 32 | System-bus address to decode |
| cs | output | 8 | One-hot chip selects |
| hit | output | 1 | Some chip select is active |
| miss | output | 1 | No chip select is active |
| hit_valid | output | 1 | hit registered one cycle later |

## Verification
A corrupted configuration word is visible on the very next cycle. It shows on cs for any address inside or just outside its window, and one cycle after its offset is placed on the read port. A wrongly latched strap swaps cs[0] and cs[1] and flips the reset enable bits of words 0 and 1, which can be seen on the first read after reset. A wrong priority or capture decision shows combinationally as a second active select or as the wrong line. A stale hit register lags hit by more than one cycle and is exposed by alternating hit and miss addresses.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  // Fixed geometry of one configuration word
  localparam int WORD_W   = 32;
  localparam int GRAN_LSB = 17;
  localparam int FLD_W    = WORD_W - GRAN_LSB;
  localparam int PAD_W    = GRAN_LSB - FLD_W - 1;

  typedef logic [FLD_W-1:0] fld_t;

  typedef struct packed {
    fld_t base;
    fld_t mask;
    logic en;
  } bank_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_to_word(input bank_cfg_t c);
    return {c.base, {PAD_W{1'b0}}, c.mask, c.en};
  endfunction

  function automatic bank_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    bank_cfg_t c;
    c.base = w[WORD_W-1 -: FLD_W];
    c.mask = w[FLD_W:1];
    c.en   = w[0];
    return c;
  endfunction
endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int REG_AW      = 8,
  parameter int STRIDE_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       strap,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic                       reg_wr,
  input  logic [WORD_W-1:0]          reg_wdata,
  output logic [WORD_W-1:0]          reg_rdata,
  output bank_cfg_t [NUM_BANKS-1:0]  cfg,
  output logic [NUM_BANKS-1:0]       is_zero,
  output logic                       swap
);
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic             off_ok;
  logic [IDX_W-1:0] idx;
  bank_cfg_t        wcfg;
  logic             unused_pad;

  assign idx        = reg_addr[STRIDE_LOG2 +: IDX_W];
  assign off_ok     = (reg_addr[STRIDE_LOG2-1:0] == '0) &&
                      ((reg_addr >> STRIDE_LOG2) < REG_AW'(NUM_BANKS));
  assign wcfg       = word_to_cfg(reg_wdata);
  assign unused_pad = ^reg_wdata[GRAN_LSB-1 -: PAD_W];

  // Strap capture while reset is held
  always_ff @(posedge clk) begin
    if (rst) swap <= strap;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_cfg_t rst_val;
    if (b == 0) begin : g_r0
      assign rst_val = '{base: '0, mask: '1, en: ~strap};
    end else if (b == 1) begin : g_r1
      assign rst_val = '{base: '0, mask: '1, en: strap};
    end else begin : g_rn
      assign rst_val = '0;
    end

    always_ff @(posedge clk) begin
      if (rst)
        cfg[b] <= rst_val;
      else if (reg_wr && off_ok && (idx == IDX_W'(b)))
        cfg[b] <= wcfg;
    end

    assign is_zero[b] = (cfg[b] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (off_ok) reg_rdata <= cfg_to_word(cfg[idx]);
    else             reg_rdata <= '0;
  end
endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match
  import cs_dec_pkg::*;
(
  input  fld_t      addr_hi,
  input  bank_cfg_t cfg,
  output logic      match
);
  assign match = cfg.en && (((addr_hi ^ cfg.base) & cfg.mask) == '0);
endmodule

// File: rtl/cs_prio_route.sv
module cs_prio_route #(
  parameter int NUM_BANKS = 8
) (
  input  logic [NUM_BANKS-1:0] raw,
  input  logic [1:0]           low_zero,
  input  logic                 swap,
  output logic [NUM_BANKS-1:0] cs
);
  logic [NUM_BANKS-1:0] pick;
  logic                 found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    if (low_zero[0]) begin
      pick[0] = 1'b1;
    end else if (low_zero[1]) begin
      pick[1] = 1'b1;
    end else begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (raw[i] && !found) begin
          pick[i] = 1'b1;
          found   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    cs = pick;
    if (swap) begin
      cs[0] = pick[1];
      cs[1] = pick[0];
    end
  end
endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int REG_AW      = 8,
  parameter int STRIDE_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 swap_strap,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic [WORD_W-1:0]    bus_addr,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 hit,
  output logic                 miss,
  output logic                 hit_valid
);
  bank_cfg_t [NUM_BANKS-1:0] cfg;
  logic [NUM_BANKS-1:0]      bank_zero;
  logic [NUM_BANKS-1:0]      raw_match;
  logic                      swap_q;
  fld_t                      addr_hi;
  logic                      unused_low;

  assign addr_hi    = bus_addr[WORD_W-1 -: FLD_W];
  assign unused_low = ^bus_addr[GRAN_LSB-1:0];

  cs_bank_regs #(
    .NUM_BANKS  (NUM_BANKS),
    .REG_AW     (REG_AW),
    .STRIDE_LOG2(STRIDE_LOG2)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .strap    (swap_strap),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cfg      (cfg),
    .is_zero  (bank_zero),
    .swap     (swap_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    cs_bank_match u_match (
      .addr_hi(addr_hi),
      .cfg    (cfg[b]),
      .match  (raw_match[b])
    );
  end

  cs_prio_route #(.NUM_BANKS(NUM_BANKS)) u_route (
    .raw     (raw_match),
    .low_zero(bank_zero[1:0]),
    .swap    (swap_q),
    .cs      (cs)
  );

  assign hit  = |cs;
  assign miss = ~hit;

  always_ff @(posedge clk) begin
    if (rst) hit_valid <= 1'b0;
    else     hit_valid <= hit;
  end
endmodule

// File: rtl/cs_addr_decoder_chk.sv
module cs_addr_decoder_chk #(
  parameter int NUM_BANKS   = 8,
  parameter int REG_AW      = 8,
  parameter int STRIDE_LOG2 = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [REG_AW-1:0]    reg_addr,
  input logic [31:0]          reg_rdata,
  input logic [NUM_BANKS-1:0] cs,
  input logic                 hit,
  input logic                 miss,
  input logic                 hit_valid,
  input logic                 swap_q,
  input logic [1:0]           low_zero
);
  logic bad_off;
  logic cap_line;

  assign bad_off  = (reg_addr[STRIDE_LOG2-1:0] != '0) ||
                    ((reg_addr >> STRIDE_LOG2) >= REG_AW'(NUM_BANKS));
  assign cap_line = swap_q ? cs[1] : cs[0];

  AST_CS_ONEHOT:   assert property (@(posedge clk) disable iff (rst) $onehot0(cs));                     // R5
  AST_MISS_QUIET:  assert property (@(posedge clk) disable iff (rst) miss |-> (cs == '0));              // R11
  AST_HITV_SET:    assert property (@(posedge clk) disable iff (rst) hit |=> hit_valid);                // R11
  AST_HITV_CLR:    assert property (@(posedge clk) disable iff (rst) !hit |=> !hit_valid);              // R11
  AST_BADOFF_ZERO: assert property (@(posedge clk) disable iff (rst) bad_off |=> (reg_rdata == '0));    // R9
  AST_CAPTURE_LOW: assert property (@(posedge clk) disable iff (rst) low_zero[0] |-> (cap_line && $countones(cs) == 1)); // R6
  AST_SWAP_HELD:   assert property (@(posedge clk) disable iff (rst) !rst |=> $stable(swap_q));         // R8
endmodule

bind cs_addr_decoder cs_addr_decoder_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .REG_AW     (REG_AW),
  .STRIDE_LOG2(STRIDE_LOG2)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .cs       (cs),
  .hit      (hit),
  .miss     (miss),
  .hit_valid(hit_valid),
  .swap_q   (swap_q),
  .low_zero (bank_zero[1:0])
);

// File: tb/cs_addr_decoder_test.sv
module cs_addr_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        swap_strap = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] bus_addr = '0;
  logic [7:0]  cs;
  logic        hit, miss, hit_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cs_addr_decoder uut (
    .clk(clk), .rst(rst), .swap_strap(swap_strap),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_addr(bus_addr), .cs(cs),
    .hit(hit), .miss(miss), .hit_valid(hit_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; swap_strap = strap; reg_wr = 1'b0; bus_addr = 32'h0;
    repeat (3) @(negedge clk);
    chk("R11 hit_valid low in reset", {31'b0, hit_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    swap_strap = ~strap;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic dec(input string tag, input logic [31:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, {24'b0, cs}, {24'b0, exp});
    chk(tag, {30'b0, hit, miss}, {30'b0, |exp, ~|exp});
  endtask

  task automatic t_reset_plain;
    logic [31:0] d;
    do_reset(1'b0);
    rd(8'h00, d); chk("R1 word0 reset", d, 32'h0000FFFF);
    rd(8'h10, d); chk("R1 word1 reset", d, 32'h0000FFFE);
    for (int k = 2; k < 8; k++) begin
      rd(8'(k * 16), d); chk("R1 upper word reset", d, 32'h0);
    end
    dec("R3 boot window", 32'h0000_1000, 8'h01);
    dec("R3 outside boot window", 32'h0002_0000, 8'h00);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, d); chk("R2 bit16 reads zero", d, 32'hFFFE_FFFF);
    @(negedge clk); reg_addr = 8'h34; #1;
    chk("R10 read data held until edge", reg_rdata, 32'hFFFE_FFFF);
    @(posedge clk); #1;
    chk("R9 misaligned offset reads zero", reg_rdata, 32'h0);
    wr(8'h34, 32'h1234_5678);
    wr(8'h31, 32'h0);
    rd(8'h30, d); chk("R9 misaligned write ignored", d, 32'hFFFE_FFFF);
    wr(8'h80, 32'hDEAD_BEEF);
    rd(8'h80, d); chk("R9 offset past last word reads zero", d, 32'h0);
    wr(8'h30, 32'h0);
    rd(8'h30, d); chk("R2 word3 cleared", d, 32'h0);
  endtask

  task automatic t_match;
    wr(8'h20, 32'h4000_FFF1);
    dec("R3 inside 1MB window", 32'h400F_FFFC, 8'h04);
    dec("R3 just past 1MB window", 32'h4010_0000, 8'h00);
    wr(8'h20, 32'h4000_FFF0);
    dec("R4 disabled word silent", 32'h4000_0000, 8'h00);
    wr(8'h20, 32'h4000_FFF1);
  endtask

  task automatic t_priority;
    wr(8'h40, 32'h4000_FF01);
    dec("R5 lower word wins overlap", 32'h4000_0000, 8'h04);
    dec("R5 only wide word matches", 32'h4080_0000, 8'h10);
  endtask

  task automatic t_capture;
    wr(8'h00, 32'h0);
    dec("R6 zero word0 captures", 32'h4000_0000, 8'h01);
    wr(8'h10, 32'h0);
    dec("R6 word0 precedes word1", 32'h4080_0000, 8'h01);
    wr(8'h00, 32'hFFFF_FFFF);
    dec("R6 zero word1 captures", 32'h4000_0000, 8'h02);
  endtask

  task automatic t_park;
    wr(8'h10, 32'hFFFF_FFFF);
    dec("R7 parked low words release bus", 32'h4000_0000, 8'h04);
    dec("R7 parked word0 top window", 32'hFFFF_0000, 8'h01);
  endtask

  task automatic t_hitq;
    dec("R11 hit address", 32'h4000_0000, 8'h04);
    @(posedge clk); #1;
    chk("R11 hit_valid follows hit", {31'b0, hit_valid}, 32'h1);
    dec("R11 miss address", 32'h2000_0000, 8'h00);
    @(posedge clk); #1;
    chk("R11 hit_valid follows miss", {31'b0, hit_valid}, 32'h0);
  endtask

  task automatic t_swap;
    logic [31:0] d;
    do_reset(1'b1);
    rd(8'h00, d); chk("R1 word0 reset swapped", d, 32'h0000FFFE);
    rd(8'h10, d); chk("R1 word1 reset swapped", d, 32'h0000FFFF);
    rd(8'h20, d); chk("R1 word2 reset swapped", d, 32'h0);
    dec("R8 word1 drives cs0", 32'h0000_0000, 8'h01);
    wr(8'h00, 32'h4000_FFF1);
    dec("R8 word0 drives cs1 after strap drop", 32'h4000_0000, 8'h02);
    wr(8'h20, 32'h4000_FFF1);
    dec("R8 word0 still outranks word2", 32'h4000_0000, 8'h02);
    wr(8'h10, 32'h0);
    dec("R6 zero word1 captures to cs0 when swapped", 32'h4000_0000, 8'h01);
  endtask

  initial begin
    t_reset_plain();
    t_layout();
    t_match();
    t_priority();
    t_capture();
    t_park();
    t_hitq();
    t_swap();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule